// File: doc/BRIEF.md
# System Reset Control Register

This block is a one-byte control register that sits on a byte-wide I/O bus at port 0xCF9. Software writes it to ask for a system reset, and reads it back to see which reset flavour has been chosen. If a write has the trigger bit set, the block raises a reset request toward the chip's reset sequencer and leaves the stored byte as it was. Any other write to the port keeps only the reset-type bit and clears the rest of the byte.

The reset request is a single-clock pulse in the cycle after the write is accepted. The sequencer that acts on the request, and the hard or soft behaviour that the type bit selects, are outside this block. The read path is combinational. It returns the stored byte zero-extended to the bus width, but only while a read is aimed at the port. Otherwise it returns zero.

Top module: `rstctl_top`

## Requirements
- R1: After reset the stored byte is 0x00 and `sys_rst_req` is low.
- R2: A write to any address other than 0xCF9 changes neither the stored byte nor `sys_rst_req`, and a read of such an address returns zero.
- R3: A write to 0xCF9 with data bit 2 set makes `sys_rst_req` high for exactly the next clock cycle. `sys_rst_req` is never high unless the previous cycle held such a write.
- R4: A write to 0xCF9 with data bit 2 set leaves the stored byte unchanged.
- R5: A write to 0xCF9 with data bit 2 clear stores data bit 1 in bit 1 and zero in every other bit. For example, 0xFB stores 0x02 and 0xF9 stores 0x00.
- R6: A read of 0xCF9 returns the stored byte in bits 7:0, with all higher bus bits zero. A read can only ever return 0x00 or 0x02.
- R7: A read has no side effect: it changes neither the stored byte nor `sys_rst_req`.
- R8: When read and write strobes are active in the same cycle, the write takes effect and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| io_addr | input | ADDR_W (16) | I/O byte address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W (8) | Write data, low byte used |
| io_rdata | output | DATA_W (8) | Read data, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the strobes are driven to clean 0 or 1 values and do not change within a cycle. They also assume that reset is held for at least one clock edge before any access. The bench drives every input on the falling edge and holds reset low for several cycles before the first access. It then runs trigger writes (including back-to-back ones), masked writes, reads and misses, and cycles with both strobes set, so that every property is exercised.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
   // kind of access seen at the port this cycle
   typedef enum logic [2:0] {
      ACC_NONE     = 3'd0,
      ACC_MISS     = 3'd1,
      ACC_READ     = 3'd2,
      ACC_WR_TRIG  = 3'd3,
      ACC_WR_KEEP  = 3'd4
   } acc_e;

   localparam int REG_W = 8;

   function automatic logic [REG_W-1:0] bit_mask(input int pos);
      logic [REG_W-1:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
   import rstctl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'hCF9,
   parameter int TRIG_POS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output acc_e              acc
);
   logic hit;
   assign hit = (addr == PORT_ADDR);

   always_comb begin
      acc = ACC_NONE;
      if (wr) begin
         if (!hit)                acc = ACC_MISS;
         else if (wdata[TRIG_POS]) acc = ACC_WR_TRIG;
         else                     acc = ACC_WR_KEEP;
      end else if (rd) begin
         acc = hit ? ACC_READ : ACC_MISS;
      end
   end
endmodule

// File: rtl/rstctl_store.sv
module rstctl_store
   import rstctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TYPE_POS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [REG_W-1:0]  kept_q
);
   localparam logic [REG_W-1:0] KEEP_MASK = bit_mask(TYPE_POS);

   always_ff @(posedge clk) begin
      if (!rst_n)                  kept_q <= '0;
      else if (acc == ACC_WR_KEEP) kept_q <= wdata[REG_W-1:0] & KEEP_MASK;
   end
endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse
   import rstctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  acc_e acc,
   output logic req_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= (acc == ACC_WR_TRIG);
   end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'hCF9,
   parameter int TRIG_POS = 2,
   parameter int TYPE_POS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              sys_rst_req
);
   localparam int PAD_W = DATA_W - REG_W;

   if (DATA_W < REG_W) begin : g_bad_data_w
      $error("rstctl_top: DATA_W must be at least one byte");
   end
   if (TRIG_POS >= REG_W || TYPE_POS >= REG_W || TRIG_POS == TYPE_POS) begin : g_bad_pos
      $error("rstctl_top: bit positions must differ and fit in a byte");
   end
   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("rstctl_top: ADDR_W too narrow for the port address");
   end

   acc_e            acc;
   logic [REG_W-1:0] kept_q;
   logic [REG_W-1:0] rd_byte;

   rstctl_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .TRIG_POS(TRIG_POS)
   ) u_decode (
      .addr(io_addr), .wr(io_wr), .rd(io_rd), .wdata(io_wdata), .acc(acc)
   );

   rstctl_store #(.DATA_W(DATA_W), .TYPE_POS(TYPE_POS)) u_store (
      .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(io_wdata), .kept_q(kept_q)
   );

   rstctl_pulse u_pulse (
      .clk(clk), .rst_n(rst_n), .acc(acc), .req_q(sys_rst_req)
   );

   assign rd_byte = (acc == ACC_READ) ? kept_q : '0;

   if (PAD_W > 0) begin : g_pad
      assign io_rdata = {{PAD_W{1'b0}}, rd_byte};
   end else begin : g_nopad
      assign io_rdata = rd_byte;
   end
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'hCF9,
   parameter int TRIG_POS = 2,
   parameter int TYPE_POS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic              sys_rst_req,
   input logic [7:0]        stored
);
   logic hit, trig_wr, keep_wr;
   logic [DATA_W-1:0] type_only;
   assign hit     = (io_addr == PORT_ADDR);
   assign trig_wr = io_wr && hit && io_wdata[TRIG_POS];
   assign keep_wr = io_wr && hit && !io_wdata[TRIG_POS];
   always_comb begin
      type_only = '0;
      type_only[TYPE_POS] = 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stored == 8'h00 && !sys_rst_req));
   // R2
   miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && hit) |=> $stable(stored));
   // R3
   trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> sys_rst_req);
   // R3
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(trig_wr));
   // R4
   trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> $stable(stored));
   // R5
   keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keep_wr |=> (stored == {6'd0, $past(io_wdata[TYPE_POS]), 1'b0}));
   // R6
   rdata_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rdata & ~type_only) == '0);
   // R8
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_rd) |-> io_rdata == '0);
endmodule

bind rstctl_top rstctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
   .TRIG_POS(TRIG_POS), .TYPE_POS(TYPE_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .sys_rst_req(sys_rst_req),
   .stored(kept_q)
);

// File: tb/tb_rstctl_top.sv
module tb_rstctl_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        sys_rst_req;

   always #10 clk = ~clk;

   rstctl_top dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .sys_rst_req(sys_rst_req)
   );

   typedef struct {
      logic [7:0] rdata;
      logic       req;
      string      tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] m_reg = 8'h00;
   logic       m_pulse = 1'b0;

   task automatic cyc(input logic [15:0] a, input logic w, input logic r,
                      input logic [7:0] d, input string tag);
      item_t it;
      logic hit;
      @(negedge clk);
      io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
      hit = (a == 16'hCF9);
      it.rdata = (r && !w && hit) ? m_reg : 8'h00;
      it.req   = m_pulse;
      it.tag   = tag;
      q.push_back(it);
      m_pulse = w && hit && d[2];
      if (w && hit && !d[2]) m_reg = d & 8'h02;
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (io_rdata !== it.rdata || sys_rst_req !== it.req) begin
               bad++;
               $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                        it.tag, io_rdata, sys_rst_req, it.rdata, it.req);
            end
         end
      end
   end

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cyc(16'hCF9, 0, 1, 8'h00, "R1 reset value");
      cyc(16'hCF9, 0, 0, 8'h00, "R1 no request");
      cyc(16'hCF9, 1, 0, 8'hFB, "R5 write 0xFB");
      cyc(16'hCF9, 0, 1, 8'h00, "R5 read 0x02");
      cyc(16'hCF9, 0, 1, 8'h00, "R7 read again");
      cyc(16'hCF9, 1, 0, 8'h04, "R3 trigger write");
      cyc(16'hCF9, 0, 1, 8'h00, "R3 pulse and R4 hold");
      cyc(16'hCF9, 0, 0, 8'h00, "R3 pulse ends");
      cyc(16'hCF9, 1, 0, 8'hF9, "R5 write 0xF9");
      cyc(16'hCF9, 0, 1, 8'h00, "R5 read 0x00");
      cyc(16'hCF8, 1, 0, 8'h02, "R2 miss write type");
      cyc(16'hCF9, 0, 1, 8'h00, "R2 unchanged");
      cyc(16'h0CF9 ^ 16'h1000, 1, 0, 8'h04, "R2 miss trigger");
      cyc(16'hCF9, 0, 0, 8'h00, "R2 no pulse");
      cyc(16'hCF9, 1, 0, 8'h02, "R5 write 0x02");
      cyc(16'hCFA, 0, 1, 8'h00, "R2 miss read zero");
      cyc(16'hCF9, 1, 0, 8'h06, "R4 trigger with type");
      cyc(16'hCF9, 1, 0, 8'hFF, "R3 back-to-back trigger");
      cyc(16'hCF9, 0, 1, 8'h00, "R4 still 0x02");
      cyc(16'hCF9, 1, 1, 8'h00, "R8 both strobes");
      cyc(16'hCF9, 0, 1, 8'h00, "R8 write applied");
      cyc(16'hCF9, 1, 1, 8'h04, "R8 both with trigger");
      cyc(16'hCF9, 0, 1, 8'h00, "R6 read after trigger");
      cyc(16'hCF9, 1, 0, 8'h0A, "R6 write 0x0A");
      cyc(16'hCF9, 0, 1, 8'h00, "R6 read only bit1");
      for (int i = 0; i < 3; i++) cyc(16'hCF9, 0, 1, 8'h00, "R7 repeated read");
      rst_n = 1'b0;
      m_reg = 8'h00; m_pulse = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cyc(16'hCF9, 0, 1, 8'h00, "R1 cleared by reset");
      cyc(16'hCF9, 0, 0, 8'h00, "idle");
      @(negedge clk);
      #8;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule